// File: doc/BRIEF.md
# Single-Accumulator Instruction Processor

This block is a small stored-program machine built around one working register, the accumulator. It keeps a program counter and an instruction register beside it. It also holds its own unified, word-addressed memory of 16-bit words. In a loop, it reads the word the program counter points at into the instruction register, steps the program counter, and then carries out that instruction. Only three operations exist: fetch a memory word into the accumulator, add a memory word to the accumulator, and write the accumulator back to memory. Every other opcode stops the machine.

A host port is used to fill and inspect the memory. A host normally writes the program and its data while reset is held. It then releases reset with the wanted start address on `start_addr` and waits for `halted`. After that it reads the results back through the same port. The program counter, instruction register and accumulator are always visible on debug outputs.

Top module: `accum_cpu`

## Requirements
- R1: While reset is active, `pc_o` equals `start_addr`, `ac_o` and `ir_o` are zero and `halted` is low. The active-low reset `rst_n` asserts at once, and its release takes effect after two rising clock edges.
- R2: An instruction is one 16-bit word. Bits [15:12] hold the opcode and bits [11:0] hold the operand address. A fetch copies memory[PC] into `ir_o` and then adds one to the PC. Operand accesses use the address in the instruction register, never the PC.
- R3: Opcode 0x1 copies the word at the operand address into the accumulator.
- R4: Opcode 0x5 adds the word at the operand address to the accumulator modulo 2^16, and any carry is dropped.
- R5: Opcode 0x2 writes the accumulator to the operand address and replaces the old word. A later load or add from that address sees the new value.
- R6: Any other opcode, 0x0 included, raises `halted` and stops execution. From then on the PC (left one past the halting word), the accumulator, the instruction register and the memory stay unchanged until reset.
- R7: Memory reads take one cycle. An add or a load takes 4 clock cycles, a store takes 3, and reaching the halted state from fetching a halting word takes 3.
- R8: A host write (`host_we`) stores `host_wdata` at `host_addr` when the machine is not storing in that cycle. `host_rdata` shows the word at `host_addr` one clock after the address is presented.
- R9: Start at 0x500 with 0x0004 at 0x781, 0x0002 at 0x782, and the words 0x1781, 0x5782, 0x2782, 0x0000 at 0x500 onward. The machine halts with the accumulator at 0x0006, 0x782 holding 0x0006 and the PC at 0x504, and `halted` rises on the 16th rising edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_addr | input | 12 | PC value loaded by reset |
| host_we | input | 1 | Host memory write enable |
| host_addr | input | 12 | Host memory address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, one cycle after the address |
| halted | output | 1 | Machine has stopped on a non-supported opcode |
| pc_o | output | 12 | Program counter view |
| ir_o | output | 16 | Instruction register view |
| ac_o | output | 16 | Accumulator view |

## Verification
The bench checks that the sum wraps: 0xFFFF+0x0001 and 0x8000+0x8000 must leave zero. A design that kept a carry, or widened the accumulator, would show a nonzero value there. It also runs a store followed by an add from the same address. A design that read stale memory, or took the operand from the PC instead of the address field, would give the wrong doubled value. An unsupported opcode placed before a store must leave the stored location and the accumulator untouched, which catches a design that runs on past the halt. The bench also counts exact cycles to the halt, which catches an extra or missing wait state in the fetch or operand path.

// File: rtl/accum_pkg.sv
package accum_pkg;
  localparam logic [3:0] OPC_LOAD  = 4'h1;
  localparam logic [3:0] OPC_ADD   = 4'h5;
  localparam logic [3:0] OPC_STORE = 4'h2;

  typedef enum logic [2:0] {
    ST_FETCH = 3'd0,
    ST_IRLD  = 3'd1,
    ST_EXEC  = 3'd2,
    ST_OPND  = 3'd3,
    ST_HALT  = 3'd4
  } cpu_state_e;
endpackage

// File: rtl/accum_rst_sync.sv
module accum_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/accum_mem.sv
module accum_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words_q [DEPTH];
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  // machine store has priority over the host port
  always_comb begin
    wr_en   = cpu_we | host_we;
    wr_addr = cpu_we ? cpu_addr  : host_addr;
    wr_data = cpu_we ? cpu_wdata : host_wdata;
  end

  always_ff @(posedge clk) begin
    if (wr_en) words_q[wr_addr] <= wr_data;
    cpu_rdata  <= words_q[cpu_addr];
    host_rdata <= words_q[host_addr];
  end
endmodule

// File: rtl/accum_ctrl.sv
module accum_ctrl
  import accum_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OPC_W  = 4,
  localparam int ADDR_W = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              ac_ld,
  output logic              ac_add,
  output logic [ADDR_W-1:0] pc_q,
  output logic [DATA_W-1:0] ir_q,
  output logic              halted_o
);
  cpu_state_e        state_q, state_d;
  logic              pc_en, ir_en;
  logic [OPC_W-1:0]  opcode;
  logic [ADDR_W-1:0] opnd_addr;

  assign opcode    = ir_q[DATA_W-1 -: OPC_W];
  assign opnd_addr = ir_q[ADDR_W-1:0];

  always_comb begin
    state_d = state_q;
    pc_en   = 1'b0;
    ir_en   = 1'b0;
    mem_we  = 1'b0;
    ac_ld   = 1'b0;
    ac_add  = 1'b0;
    case (state_q)
      ST_FETCH: state_d = ST_IRLD;
      ST_IRLD: begin
        ir_en   = 1'b1;
        pc_en   = 1'b1;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        case (opcode)
          OPC_LOAD, OPC_ADD: state_d = ST_OPND;
          OPC_STORE: begin
            mem_we  = 1'b1;
            state_d = ST_FETCH;
          end
          default: state_d = ST_HALT;
        endcase
      end
      ST_OPND: begin
        ac_ld   = (opcode == OPC_LOAD);
        ac_add  = (opcode == OPC_ADD);
        state_d = ST_FETCH;
      end
      default: state_d = ST_HALT;
    endcase
  end

  assign mem_addr = (state_q == ST_FETCH) ? pc_q : opnd_addr;
  assign halted_o = (state_q == ST_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      pc_q    <= start_addr;
      ir_q    <= '0;
    end else begin
      state_q <= state_d;
      if (pc_en) pc_q <= pc_q + 1'b1;
      if (ir_en) ir_q <= mem_rdata;
    end
  end

  // R2: PC advances by exactly one on each instruction latch
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IRLD) |=> (pc_q == ADDR_W'($past(pc_q) + 1'b1)));

  // R6: halted state is sticky and freezes PC and IR
  assert_halt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> (halted_o && $stable(pc_q) && $stable(ir_q)));
endmodule

// File: rtl/accum_reg.sv
module accum_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ac_ld,
  input  logic              ac_add,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] ac_q
);
  logic [DATA_W-1:0] ac_d;
  logic              ac_en;

  always_comb begin
    ac_en = ac_ld | ac_add;
    ac_d  = ac_add ? (ac_q + mem_rdata) : mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ac_q <= '0;
    else if (ac_en) ac_q <= ac_d;
  end
endmodule

// File: rtl/accum_cpu.sv
module accum_cpu
  import accum_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int OPC_W       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              halted,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [DATA_W-1:0] ac_o
);
  logic              rst_int_n;
  logic [ADDR_W-1:0] cpu_addr;
  logic              cpu_we;
  logic [DATA_W-1:0] mem_rdata;
  logic              ac_ld, ac_add;

  accum_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_int_n)
  );

  accum_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk),
    .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(ac_o), .cpu_rdata(mem_rdata),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata)
  );

  accum_ctrl #(.DATA_W(DATA_W), .OPC_W(OPC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .start_addr(start_addr),
    .mem_rdata(mem_rdata), .mem_addr(cpu_addr), .mem_we(cpu_we),
    .ac_ld(ac_ld), .ac_add(ac_add),
    .pc_q(pc_o), .ir_q(ir_o), .halted_o(halted)
  );

  accum_reg #(.DATA_W(DATA_W)) u_ac (
    .clk(clk), .rst_n(rst_int_n), .ac_ld(ac_ld), .ac_add(ac_add),
    .mem_rdata(mem_rdata), .ac_q(ac_o)
  );

  // R3: a load leaves the returned memory word in the accumulator
  assert_load_value_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    ac_ld |=> (ac_o == $past(mem_rdata)));

  // R4: an add leaves the wrapped sum
  assert_add_wrap_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    ac_add |=> (ac_o == DATA_W'($past(ac_o) + $past(mem_rdata))));

  // R5: memory is written by the machine only for a store instruction
  assert_store_only_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    cpu_we |-> (ir_o[DATA_W-1 -: OPC_W] == OPC_STORE));

  // R6: accumulator frozen once halted
  assert_halt_ac_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    halted |=> $stable(ac_o));
endmodule

// File: tb/test_accum_cpu.sv
module test_accum_cpu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] start_addr;
  logic        host_we;
  logic [11:0] host_addr;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic        halted;
  logic [11:0] pc_o;
  logic [15:0] ir_o;
  logic [15:0] ac_o;

  int checks = 0;
  int errors = 0;
  int cyc;
  logic [15:0] rd;

  always #2.5 clk = ~clk;

  accum_cpu i_accum_cpu (
    .clk(clk), .rst_n(rst_n), .start_addr(start_addr),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .halted(halted),
    .pc_o(pc_o), .ir_o(ir_o), .ac_o(ac_o)
  );

  // {operand at 0x781, operand at 0x782, expected result}
  localparam logic [47:0] VECS [5] = '{
    48'h0004_0002_0006,
    48'hFFFF_0001_0000,
    48'h8000_8000_0000,
    48'h1234_4321_5555,
    48'h0000_0000_0000
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic peek(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic run_to_halt();
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 200) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic enter_reset(input logic [11:0] sa);
    @(negedge clk);
    rst_n = 1'b0;
    start_addr = sa;
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; start_addr = 12'h500;
    host_we = 1'b0; host_addr = '0; host_wdata = '0;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1 pc", {4'h0, pc_o}, 16'h0500);
    chk("R1 ac", ac_o, 16'h0000);
    chk("R1 ir", ir_o, 16'h0000);
    chk("R1 halted", {15'd0, halted}, 16'h0000);

    // R9 / R2 / R3 / R4 / R5 / R7: table-driven runs of the add program
    for (int i = 0; i < 5; i++) begin
      enter_reset(12'h500);
      poke(12'h500, 16'h1781);
      poke(12'h501, 16'h5782);
      poke(12'h502, 16'h2782);
      poke(12'h503, 16'h0000);
      poke(12'h781, VECS[i][47:32]);
      poke(12'h782, VECS[i][31:16]);
      chk("R1 ac cleared in reset", ac_o, 16'h0000);
      run_to_halt();
      chk("R7 cycles to halt", 16'(cyc), 16'd16);
      chk("R4 R9 accumulator", ac_o, VECS[i][15:0]);
      chk("R2 pc after halt", {4'h0, pc_o}, 16'h0504);
      peek(12'h782, rd);
      chk("R5 R9 stored sum", rd, VECS[i][15:0]);
      peek(12'h781, rd);
      chk("R3 operand untouched", rd, VECS[i][47:32]);
    end

    // R5 / R2: store then add from the stored location, other start address
    enter_reset(12'h010);
    poke(12'h010, 16'h1781);
    poke(12'h011, 16'h2790);
    poke(12'h012, 16'h5790);
    poke(12'h013, 16'h2791);
    poke(12'h014, 16'h0000);
    poke(12'h781, 16'h0003);
    poke(12'h790, 16'hBEEF);
    chk("R1 pc from start_addr", {4'h0, pc_o}, 16'h0010);
    run_to_halt();
    chk("R7 store-heavy cycles", 16'(cyc), 16'd19);
    chk("R5 readback after store", ac_o, 16'h0006);
    peek(12'h790, rd);
    chk("R5 overwrite", rd, 16'h0003);
    peek(12'h791, rd);
    chk("R5 second store", rd, 16'h0006);

    // R6: unsupported opcode stops before a following store
    enter_reset(12'h600);
    poke(12'h600, 16'h1781);
    poke(12'h601, 16'h7123);
    poke(12'h602, 16'h2782);
    poke(12'h781, 16'h00AA);
    poke(12'h782, 16'h1111);
    run_to_halt();
    chk("R6 halted", {15'd0, halted}, 16'h0001);
    chk("R7 cycles to illegal halt", 16'(cyc), 16'd9);
    chk("R6 ir holds illegal word", ir_o, 16'h7123);
    repeat (6) @(negedge clk);
    chk("R6 pc frozen", {4'h0, pc_o}, 16'h0602);
    chk("R6 ac frozen", ac_o, 16'h00AA);
    peek(12'h782, rd);
    chk("R6 memory untouched", rd, 16'h1111);

    // R8: host write then read with one-cycle latency
    poke(12'hABC, 16'h5A5A);
    @(negedge clk);
    host_addr = 12'hABC;
    @(negedge clk);
    chk("R8 host read latency", host_rdata, 16'h5A5A);

    // R1: asynchronous reset asserted mid-run
    enter_reset(12'h500);
    poke(12'h781, 16'h0004);
    poke(12'h782, 16'h0002);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async pc", {4'h0, pc_o}, 16'h0500);
    chk("R1 async ac", ac_o, 16'h0000);
    chk("R1 async halted", {15'd0, halted}, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule